// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This controller holds the chip's operating mode: three full-power run modes and one low-power stop mode. Software asks for a new mode with three register writes. The first write selects the target mode, the second carries a fixed unlock key, and the third carries the bitwise complement of that key. When the third write is accepted, the controller raises a request to an external power sequencer. It commits the new mode when the sequencer acknowledges.

Four asynchronous event lines report external activity: wakeup, interrupt, external reset and clock failure. Each line passes through a two-flop synchronizer. If a synchronized event is seen in the cycle the complemented key is accepted, or at any later cycle while the transition is active, the transition is abandoned. The mode that was in effect before the request is kept, and a sticky abort flag is set. The active flag comes from the same register edge that accepts the request, so no cycle exists in which a request has been taken but the controller still looks idle.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous reset sets curMode to RUN0 (0) and tgtMode to RUN0. It clears xferActive, seqReq, abortFlag and donePulse.
- R2: The transition starts only after three writes in this order: a write to address 0 (mode field in wrData[1:0]), a write to address 1 with 16'h5AF0, and a write to address 2 with 16'hA50F. At the edge that samples the last write, xferActive and seqReq both go high.
- R3: When seqAck is sampled high during an active transition and no event is present, curMode takes tgtMode. At the same edge, donePulse goes high for exactly one cycle and xferActive and seqReq go low.
- R4: A wrong key, a wrong inverted key, or a key write out of order returns the arming sequence to idle. No transition starts and curMode does not change.
- R5: A synchronized event in the accepting cycle, or during an active transition, aborts the transition. It drops xferActive and seqReq, sets abortFlag and keeps curMode. This holds even when seqAck arrives in the same cycle as the event.
- R6: An event level sampled at clock edge k acts on the control at edge k+2, through two synchronizer flops.
- R7: An event that arrives while no transition is active leaves curMode, abortFlag and the arming progress unchanged.
- R8: abortFlag stays set until the next accepted write to address 0, which clears it.
- R9: Register writes made while a transition is active are ignored.
- R10: tgtMode shows the mode field of the most recent accepted write to address 0. The mode encoding is RUN0=0, RUN1=1, RUN2=2, STOP=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 mode select, 1 key, 2 inverted key |
| wrData | input | 16 | Write data |
| evtWake | input | 1 | Asynchronous wakeup event |
| evtIrq | input | 1 | Asynchronous interrupt event |
| evtRstExt | input | 1 | Asynchronous external reset event |
| evtClkFail | input | 1 | Asynchronous clock failure event |
| seqAck | input | 1 | Power sequencer completion acknowledge |
| seqReq | output | 1 | Request to the power sequencer |
| xferActive | output | 1 | Transition in progress |
| curMode | output | 2 | Mode in effect |
| tgtMode | output | 2 | Requested mode |
| abortFlag | output | 1 | Sticky abort indication |
| donePulse | output | 1 | One-cycle pulse on successful completion |

## Verification
The hardest situation to reach is an event whose synchronized copy lands exactly on the edge that accepts the inverted key, or on the edge that samples the acknowledge. Random event timing rarely lands on these edges. The bench therefore sweeps the event pin cycle by cycle, from five cycles before the inverted-key write to six cycles after it. Each step uses a different event line and a fresh target mode. For each offset it predicts from the two-cycle synchronizer delay whether the transition completes or aborts. It then checks the mode, the abort flag and the exact cycle in which the active flag falls.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN0 = 2'd0,
    MODE_RUN1 = 2'd1,
    MODE_RUN2 = 2'd2,
    MODE_STOP = 2'd3
  } pmcMode_e;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_CFG  = 2'd1,
    ARM_KEY  = 2'd2
  } armState_e;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_KEY  = 2'd1;
  localparam logic [1:0] ADDR_NKEY = 2'd2;

  typedef struct packed {
    logic     ldTgt;
    pmcMode_e tgtVal;
    logic     clrAbort;
    logic     commit;
    logic     abort;
  } pmcStrb_t;

endpackage

// File: rtl/pmc_evt_sync.sv
module pmc_evt_sync #(
  parameter int N_EVT  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evtIn,
  output logic             evtAny
);

  logic [N_EVT-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= evtIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign evtAny = |stage[STAGES-1];

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int              KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'h5AF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [KEY_W-1:0] wrData,
  input  logic             evtAny,
  input  logic             seqAck,
  output pmcStrb_t         strb,
  output logic             busy
);

  localparam logic [KEY_W-1:0] KEY_INV = ~KEY_VAL;

  armState_e armSt, armNx;
  logic      busyNx;
  logic      cfgWr, keyWr, nkeyWr;

  assign cfgWr  = wrEn && !busy && (wrAddr == ADDR_CFG);
  assign keyWr  = wrEn && !busy && (wrAddr == ADDR_KEY);
  assign nkeyWr = wrEn && !busy && (wrAddr == ADDR_NKEY);

  always_comb begin
    strb   = '0;
    armNx  = armSt;
    busyNx = busy;
    if (busy) begin
      armNx = ARM_IDLE;
      if (evtAny) begin
        strb.abort = 1'b1;
        busyNx     = 1'b0;
      end else if (seqAck) begin
        strb.commit = 1'b1;
        busyNx      = 1'b0;
      end
    end else if (cfgWr) begin
      armNx         = ARM_CFG;
      strb.ldTgt    = 1'b1;
      strb.tgtVal   = pmcMode_e'(wrData[1:0]);
      strb.clrAbort = 1'b1;
    end else begin
      case (armSt)
        ARM_CFG: begin
          if (keyWr)       armNx = (wrData == KEY_VAL) ? ARM_KEY : ARM_IDLE;
          else if (nkeyWr) armNx = ARM_IDLE;
        end
        ARM_KEY: begin
          if (nkeyWr) begin
            armNx = ARM_IDLE;
            if (wrData == KEY_INV) begin
              if (evtAny) strb.abort = 1'b1;
              else        busyNx     = 1'b1;
            end
          end else if (keyWr) begin
            armNx = ARM_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armSt <= ARM_IDLE;
      busy  <= 1'b0;
    end else begin
      armSt <= armNx;
      busy  <= busyNx;
    end
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && armSt == ARM_KEY && wrEn && wrAddr == ADDR_NKEY &&
     wrData == KEY_INV && !evtAny) |=> busy);

  // R5
  evt_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && evtAny) |=> !busy);

  // R9
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> armSt == ARM_IDLE);

endmodule

// File: rtl/pmc_dpath.sv
module pmc_dpath
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pmcStrb_t   strb,
  output logic [1:0] curMode,
  output logic [1:0] tgtMode,
  output logic       abortFlag,
  output logic       donePulse
);

  pmcMode_e curQ, tgtQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      curQ      <= MODE_RUN0;
      tgtQ      <= MODE_RUN0;
      abortFlag <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      if (strb.ldTgt)    tgtQ <= strb.tgtVal;
      if (strb.commit)   curQ <= tgtQ;
      if (strb.clrAbort) abortFlag <= 1'b0;
      else if (strb.abort) abortFlag <= 1'b1;
      donePulse <= strb.commit;
    end
  end

  assign curMode = curQ;
  assign tgtMode = tgtQ;

  // R3
  commit_loads_chk: assert property (@(posedge clk) disable iff (rst)
    strb.commit |=> (curMode == $past(tgtMode)) && donePulse);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(curMode));

  // R8
  abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (abortFlag && !strb.clrAbort) |=> abortFlag);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int               KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY_VAL    = 16'h5AF0,
  parameter int               SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [KEY_W-1:0] wrData,
  input  logic             evtWake,
  input  logic             evtIrq,
  input  logic             evtRstExt,
  input  logic             evtClkFail,
  input  logic             seqAck,
  output logic             seqReq,
  output logic             xferActive,
  output logic [1:0]       curMode,
  output logic [1:0]       tgtMode,
  output logic             abortFlag,
  output logic             donePulse
);

  localparam int N_EVT = 4;

  logic [N_EVT-1:0] evtVec;
  logic             evtAny;
  logic             busy;
  pmcStrb_t         strb;

  assign evtVec = {evtClkFail, evtRstExt, evtIrq, evtWake};

  pmc_evt_sync #(.N_EVT(N_EVT), .STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst(rst), .evtIn(evtVec), .evtAny(evtAny)
  );

  pmc_ctrl #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtAny(evtAny), .seqAck(seqAck), .strb(strb), .busy(busy)
  );

  pmc_dpath u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .curMode(curMode), .tgtMode(tgtMode),
    .abortFlag(abortFlag), .donePulse(donePulse)
  );

  assign seqReq     = busy;
  assign xferActive = busy;

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam logic [15:0] KEY  = 16'h5AF0;
  localparam logic [15:0] NKEY = 16'hA50F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  evt = '0;
  logic        seqAck = 1'b0;
  logic        seqReq, xferActive, abortFlag, donePulse;
  logic [1:0]  curMode, tgtMode;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtWake(evt[0]), .evtIrq(evt[1]), .evtRstExt(evt[2]), .evtClkFail(evt[3]),
    .seqAck(seqAck), .seqReq(seqReq), .xferActive(xferActive),
    .curMode(curMode), .tgtMode(tgtMode), .abortFlag(abortFlag), .donePulse(donePulse)
  );

  typedef struct {
    logic [1:0] mode;
    logic       abrt;
    logic       done;
  } item_t;

  item_t q[$];
  int nChk = 0;
  int nFail = 0;
  logic [1:0] expMode = 2'd0;
  logic prevAbort = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic push(input logic [1:0] m, input logic a, input logic d);
    item_t it;
    it.mode = m; it.abrt = a; it.done = d;
    q.push_back(it);
  endtask

  // monitor: pops one expected item per completion or abort
  always @(negedge clk) begin
    if (!rst && (donePulse || (abortFlag && !prevAbort))) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3/R5 unexpected result", int'(curMode), -1);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(curMode == it.mode, "R3/R5 mode", int'(curMode), int'(it.mode));
        chk(abortFlag == it.abrt, "R5 abortFlag", int'(abortFlag), int'(it.abrt));
        chk(donePulse == it.done, "R3 donePulse", int'(donePulse), int'(it.done));
      end
    end
    prevAbort = abortFlag;
  end

  task automatic doXfer(input logic [1:0] tgt, input int dly);
    push(tgt, 1'b0, 1'b1);
    wr(2'd0, {14'd0, tgt});
    wr(2'd1, KEY);
    wr(2'd2, NKEY);
    chk(xferActive && seqReq, "R2 active at accept", int'(xferActive), 1);
    chk(tgtMode == tgt, "R10 tgtMode", int'(tgtMode), int'(tgt));
    repeat (dly) @(negedge clk);
    seqAck = 1'b1;
    @(negedge clk);
    seqAck = 1'b0;
    @(negedge clk);
    chk(!donePulse && !xferActive, "R3 single pulse", int'(donePulse), 0);
    expMode = tgt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(curMode == 2'd0, "R1 curMode", int'(curMode), 0);
    chk(tgtMode == 2'd0, "R1 tgtMode", int'(tgtMode), 0);
    chk(!xferActive && !seqReq, "R1 active", int'(xferActive), 0);
    chk(!abortFlag && !donePulse, "R1 flags", int'(abortFlag), 0);

    // R2 R3 normal transitions with varied ack delay
    doXfer(2'd1, 3);
    doXfer(2'd2, 0);
    doXfer(2'd3, 5);

    // R4 bad key
    wr(2'd0, 16'd0); wr(2'd1, 16'h1234); wr(2'd2, NKEY);
    repeat (3) @(negedge clk);
    chk(!xferActive && curMode == expMode, "R4 bad key", int'(xferActive), 0);
    // R4 bad inverted key
    wr(2'd0, 16'd0); wr(2'd1, KEY); wr(2'd2, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk(!xferActive && curMode == expMode, "R4 bad inverted key", int'(curMode), int'(expMode));
    // R4 out of order, then a lone inverted key
    wr(2'd0, 16'd1); wr(2'd2, NKEY); wr(2'd1, KEY); wr(2'd2, NKEY);
    repeat (3) @(negedge clk);
    chk(!seqReq && curMode == expMode, "R4 out of order", int'(seqReq), 0);
    chk(tgtMode == 2'd1, "R10 tgtMode follows last mode write", int'(tgtMode), 1);

    // R7 events while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); evt = 4'b1 << i;
      @(negedge clk); evt = '0;
      repeat (4) @(negedge clk);
      chk(curMode == expMode && !abortFlag && !xferActive, "R7 idle event",
          int'(curMode), int'(expMode));
    end

    // R9 write during active transition ignored
    push(2'd0, 1'b0, 1'b1);
    wr(2'd0, 16'd0); wr(2'd1, KEY); wr(2'd2, NKEY);
    wr(2'd0, 16'd2);
    chk(tgtMode == 2'd0 && xferActive, "R9 write ignored while active", int'(tgtMode), 0);
    @(negedge clk); seqAck = 1'b1;
    @(negedge clk); seqAck = 1'b0;
    @(negedge clk);
    expMode = 2'd0;
    chk(curMode == 2'd0, "R9 completes to original target", int'(curMode), 0);

    // R5 R6 R7 R8 event sweep around the inverted key write (edge 8)
    for (int d = -5; d <= 6; d++) begin
      logic [1:0] tgt;
      bit abortExp;
      int iter;
      iter = d + 5;
      tgt = expMode + 2'd1;
      abortExp = (d >= -2 && d <= 4);
      push(abortExp ? expMode : tgt, abortExp, !abortExp);
      for (int k = 0; k <= 18; k++) begin
        @(negedge clk);
        if (k == 8)
          chk(!abortFlag && tgtMode == tgt, "R8 R10 flag cleared and target loaded",
              int'(abortFlag), 0);
        if (abortExp && d >= -1 && k == 8 + d + 2)
          chk(xferActive, "R6 still active before synced event", int'(xferActive), 1);
        if (abortExp && d >= -1 && k == 8 + d + 3)
          chk(!xferActive && !seqReq, "R5 R6 dropped after synced event", int'(xferActive), 0);
        wrEn = (k >= 6 && k <= 8);
        wrAddr = (k == 6) ? 2'd0 : (k == 7) ? 2'd1 : 2'd2;
        wrData = (k == 6) ? {14'd0, tgt} : (k == 7) ? KEY : NKEY;
        evt = (k == 8 + d) ? (4'b1 << (iter % 4)) : 4'b0;
        seqAck = (k == 14);
      end
      @(negedge clk);
      wrEn = 1'b0; evt = '0; seqAck = 1'b0;
      repeat (3) @(negedge clk);
      if (!abortExp) expMode = tgt;
      chk(curMode == expMode && !xferActive, "R5 R7 mode after sweep step",
          int'(curMode), int'(expMode));
    end

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 all results observed", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule